// File: doc/BRIEF.md
# Multi-Level Interrupt Arbiter and Vectoring Logic

This block arbitrates interrupt requests for a small 8-bit processor core. At a fixed phase of every machine cycle it captures the raw request flags. It evaluates those captured flags during the following machine cycle. From the sources that are eligible, it picks one winner. The winner is the source with the highest programmed priority level. When several sources share that level, the one with the lowest slot index wins. The block then asks the core for a vectored call, unless the call is blocked.

There are three ways a call can be blocked:
- a service routine at an equal or higher level is already running;
- the poll does not fall in the last cycle of the current instruction;
- the current instruction is a return from interrupt or a write to an interrupt control register. This gives a one-instruction hold-off.

The core marks the machine-cycle phase with a tick, and it reports the last cycle of each instruction and the kind of instruction running. The block keeps one in-service bit per priority level. It sets the bit when it issues a call and clears it when a return-from-interrupt completes. Three slots are the OR of two peripheral flags. Each of these pairs shares one arbitration slot and one vector.

Top module: `irq_arb_top`

## Requirements
- R1: At a clock edge with `sampleTick` high, the combined flags are captured. They are evaluated at the next edge with `sampleTick` high. A resulting call shows as `callReq` high for exactly the one clock after that polling edge, with `vectorIdx` giving the winning slot index at the same time.
- R2: The priority level of slot i is the 2-bit value {`prioHi[g]`, `prioLo[g]`}, where g = i / 2. An eligible slot with a higher level wins over any slot with a lower level, whatever their indices.
- R3: Among eligible slots of equal level, the lowest index wins. The slot order, from highest to lowest, is:
  - 0 external request 0
  - 1 timer 0
  - 2 external request 1
  - 3 timer 1
  - 4 serial port 0
  - 5 timer 2
  - 6 serial port 1
  - 7 compare timer
  - 8 converter done
  - 9 to 13 external requests 2 to 6
- R4: Slots 4, 5 and 6 request when `flagA` or `flagB` of that slot is set. In every other slot, `flagB` has no effect.
- R5: A captured slot is eligible only if `srcEnable[i]` and `globalEnable` are both high at the polling edge.
- R6: No call is issued while `inService[j]` is set for any level j greater than or equal to the winner's level.
- R7: No call is issued if `lastCycle` is low at the polling edge.
- R8: No call is issued if `instrIsReti` or `instrIsIrqWrite` is high at the polling edge. A later instruction whose final-cycle poll is free of these flags may issue the call.
- R9: Issuing a call sets the `inService` bit of the winner's level. When `sampleTick`, `lastCycle` and `instrIsReti` are all high, the highest set `inService` bit is cleared. `inService` changes only at tick edges.
- R10: A blocked poll stores nothing. If the flag is cleared before the next capture, the request is never serviced.
- R11: Reset (`rstN` low) clears `callReq`, `vectorIdx`, `inService` and the captured flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Machine-cycle phase pulse: capture and poll edge |
| lastCycle | input | 1 | Current cycle is the last of the running instruction |
| instrIsReti | input | 1 | Running instruction is a return from interrupt |
| instrIsIrqWrite | input | 1 | Running instruction writes an interrupt enable or priority register |
| flagA | input | 14 | Primary request flag per slot |
| flagB | input | 14 | Second flag, ORed in for paired slots only |
| srcEnable | input | 14 | Per-slot enable |
| globalEnable | input | 1 | Master interrupt enable |
| prioLo | input | 7 | Low bit of each group's level |
| prioHi | input | 7 | High bit of each group's level |
| callReq | output | 1 | One-clock vectored call request |
| vectorIdx | output | 4 | Winning slot index, valid with callReq |
| inService | output | 4 | In-service bit per priority level |

## Verification
The bench builds the block with its default parameters: fourteen slots in groups of two, with slots 4 to 6 paired. This makes all four priority levels reachable, along with the full fourteen-deep tie chain and both paired and unpaired flag handling. Under these parameters, nesting can stack service routines up to the top level, so in-service blocking at every level, clearing of the highest level and each hold-off condition can all be driven by directed cases. Random cycles then mix levels, enables and core status.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef struct packed {
    logic capture;
    logic issue;
  } arbStrobe_t;
endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 14,
  parameter int SRC_PER_GRP = 2,
  parameter logic [NUM_SRC-1:0] PAIR_MASK = 'h70,
  localparam int NUM_GRP = (NUM_SRC + SRC_PER_GRP - 1) / SRC_PER_GRP,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobes,
  input  logic [NUM_SRC-1:0] flagA,
  input  logic [NUM_SRC-1:0] flagB,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEnable,
  input  logic [NUM_GRP-1:0] prioLo,
  input  logic [NUM_GRP-1:0] prioHi,
  output logic               winValid,
  output logic [LVL_W-1:0]   winLevel,
  output logic               callReq,
  output logic [IDX_W-1:0]   vectorIdx
);
  logic [NUM_SRC-1:0] combined;
  logic [NUM_SRC-1:0] sampled;
  logic [NUM_SRC-1:0] eligible;
  logic [LVL_W-1:0]   srcLevel [NUM_SRC];
  logic [IDX_W-1:0]   bestIdx;

  // pair flags share a slot; unpaired slots mask the second flag away
  assign combined = flagA | (flagB & PAIR_MASK);
  assign eligible = sampled & srcEnable & {NUM_SRC{globalEnable}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : gLevel
    localparam int G = i / SRC_PER_GRP;
    assign srcLevel[i] = {prioHi[G], prioLo[G]};
  end

  // descending scan with >= leaves the lowest index of the top level
  always_comb begin
    winValid = 1'b0;
    winLevel = '0;
    bestIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!winValid || srcLevel[i] >= winLevel)) begin
        winValid = 1'b1;
        winLevel = srcLevel[i];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampled   <= '0;
      callReq   <= 1'b0;
      vectorIdx <= '0;
    end else begin
      if (strobes.capture) sampled <= combined;
      callReq <= strobes.issue;
      if (strobes.issue) vectorIdx <= bestIdx;
    end
  end
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleTick,
  input  logic               lastCycle,
  input  logic               instrIsReti,
  input  logic               instrIsIrqWrite,
  input  logic               winValid,
  input  logic [LVL_W-1:0]   winLevel,
  output arbStrobe_t         strobes,
  output logic [NUM_LVL-1:0] inService
);
  logic               busy;
  logic               holdOff;
  logic               retire;
  logic [LVL_W-1:0]   topSet;
  logic [NUM_LVL-1:0] inSvcNext;

  assign holdOff = instrIsReti | instrIsIrqWrite;
  assign retire  = sampleTick & lastCycle & instrIsReti;

  always_comb begin
    busy = 1'b0;
    for (int j = 0; j < NUM_LVL; j++) begin
      if (inService[j] && LVL_W'(j) >= winLevel) busy = 1'b1;
    end
  end

  always_comb begin
    topSet = '0;
    for (int j = 0; j < NUM_LVL; j++) begin
      if (inService[j]) topSet = LVL_W'(j);
    end
  end

  always_comb begin
    strobes.capture = sampleTick;
    strobes.issue   = sampleTick & winValid & lastCycle & ~holdOff & ~busy;
  end

  always_comb begin
    inSvcNext = inService;
    if (strobes.issue) inSvcNext[winLevel] = 1'b1;
    else if (retire)   inSvcNext[topSet]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inService <= '0;
    else       inService <= inSvcNext;
  end
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 14,
  parameter int SRC_PER_GRP = 2,
  parameter logic [NUM_SRC-1:0] PAIR_MASK = 'h70,
  localparam int NUM_GRP = (NUM_SRC + SRC_PER_GRP - 1) / SRC_PER_GRP,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleTick,
  input  logic               lastCycle,
  input  logic               instrIsReti,
  input  logic               instrIsIrqWrite,
  input  logic [NUM_SRC-1:0] flagA,
  input  logic [NUM_SRC-1:0] flagB,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEnable,
  input  logic [NUM_GRP-1:0] prioLo,
  input  logic [NUM_GRP-1:0] prioHi,
  output logic               callReq,
  output logic [IDX_W-1:0]   vectorIdx,
  output logic [NUM_LVL-1:0] inService
);
  arbStrobe_t       strobes;
  logic             winValid;
  logic [LVL_W-1:0] winLevel;

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .SRC_PER_GRP(SRC_PER_GRP), .PAIR_MASK(PAIR_MASK)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .flagA(flagA), .flagB(flagB), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .prioLo(prioLo), .prioHi(prioHi),
    .winValid(winValid), .winLevel(winLevel),
    .callReq(callReq), .vectorIdx(vectorIdx)
  );

  irq_arb_control uCtl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lastCycle(lastCycle),
    .instrIsReti(instrIsReti), .instrIsIrqWrite(instrIsIrqWrite),
    .winValid(winValid), .winLevel(winLevel),
    .strobes(strobes), .inService(inService)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int NUM_SRC = 14,
  parameter int IDX_W   = 4,
  parameter int NUM_LVL = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleTick,
  input logic               lastCycle,
  input logic               instrIsReti,
  input logic               instrIsIrqWrite,
  input logic               globalEnable,
  input logic               callReq,
  input logic [IDX_W-1:0]   vectorIdx,
  input logic [NUM_LVL-1:0] inService
);
  a_r1_call_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(sampleTick));

  a_r1_vector_range: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> (int'(vectorIdx) < NUM_SRC));

  a_r7_final_cycle: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(lastCycle));

  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> (!$past(instrIsReti) && !$past(instrIsIrqWrite)));

  a_r5_global_enable: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(globalEnable));

  a_r9_level_added: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> ($countones(inService) == $countones($past(inService)) + 1));

  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleTick) |-> $stable(inService));
endmodule

bind irq_arb_top irq_arb_checker #(
  .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .NUM_LVL(irq_arb_pkg::NUM_LVL)
) uChk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lastCycle(lastCycle),
  .instrIsReti(instrIsReti), .instrIsIrqWrite(instrIsIrqWrite),
  .globalEnable(globalEnable), .callReq(callReq), .vectorIdx(vectorIdx),
  .inService(inService)
);

// File: tb/tb_irq_arb_top.sv
module tb_irq_arb_top;
  localparam int N = 14;
  localparam int G = 7;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sampleTick = 1'b0;
  logic         lastCycle = 1'b1;
  logic         instrIsReti = 1'b0;
  logic         instrIsIrqWrite = 1'b0;
  logic [N-1:0] flagA = '0;
  logic [N-1:0] flagB = '0;
  logic [N-1:0] srcEnable = '1;
  logic         globalEnable = 1'b1;
  logic [G-1:0] prioLo = '0;
  logic [G-1:0] prioHi = '0;
  logic         callReq;
  logic [3:0]   vectorIdx;
  logic [3:0]   inService;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [N-1:0] mSampled = '0;
  logic [3:0]   mInSvc = '0;
  bit           mCall;
  int           mVec;

  always #10 clk = ~clk;

  irq_arb_top dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lastCycle(lastCycle),
    .instrIsReti(instrIsReti), .instrIsIrqWrite(instrIsIrqWrite),
    .flagA(flagA), .flagB(flagB), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .prioLo(prioLo), .prioHi(prioHi),
    .callReq(callReq), .vectorIdx(vectorIdx), .inService(inService)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvlOf(input int i);
    return int'({prioHi[i / 2], prioLo[i / 2]});
  endfunction

  // one machine cycle: capture and poll at the tick edge
  task automatic step(input string tag);
    logic [N-1:0] elig;
    logic [N-1:0] pairs;
    int bestLvl;
    bit blocked;
    bit found;
    found = 1'b0;
    bestLvl = -1;
    mVec = -1;
    elig = mSampled & srcEnable & {N{globalEnable}};
    for (int i = 0; i < N; i++) begin
      if (elig[i] && lvlOf(i) > bestLvl) begin
        bestLvl = lvlOf(i);
        mVec = i;
        found = 1'b1;
      end
    end
    blocked = !lastCycle || instrIsReti || instrIsIrqWrite;
    for (int j = 0; j < 4; j++) if (mInSvc[j] && j >= bestLvl) blocked = 1'b1;
    mCall = found && !blocked;
    if (mCall) mInSvc[bestLvl] = 1'b1;
    else if (lastCycle && instrIsReti) begin
      for (int j = 3; j >= 0; j--) begin
        if (mInSvc[j]) begin
          mInSvc[j] = 1'b0;
          break;
        end
      end
    end
    pairs = '0;
    pairs[4] = 1'b1; pairs[5] = 1'b1; pairs[6] = 1'b1;
    mSampled = flagA | (flagB & pairs);

    sampleTick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sampleTick = 1'b0;
    chk({tag, " callReq"}, int'(callReq), int'(mCall));
    if (mCall) chk({tag, " vectorIdx"}, int'(vectorIdx), mVec);
    chk({tag, " inService"}, int'(inService), int'(mInSvc));
    @(posedge clk);
    @(negedge clk);
    chk("R1 pulse width", int'(callReq), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input string tag, input logic [N-1:0] a, input logic [N-1:0] b);
    flagA = a; flagB = b;
    step({tag, " capture"});
    flagA = '0; flagB = '0;
    step(tag);
  endtask

  task automatic retire(input string tag);
    instrIsReti = 1'b1;
    step(tag);
    instrIsReti = 1'b0;
  endtask

  task automatic expectCall(input string tag, input bit c, input int v);
    chk({tag, " literal call"}, int'(mCall), int'(c));
    if (c) chk({tag, " literal vector"}, mVec, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 callReq", int'(callReq), 0);
    chk("R11 vectorIdx", int'(vectorIdx), 0);
    chk("R11 inService", int'(inService), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 tie break within level 0
    pulse("R3 tie", 14'h2204, '0);
    expectCall("R3 tie", 1'b1, 2);
    retire("R9 retire");
    chk("R9 cleared", int'(inService), 0);

    // R2 higher level beats lower index
    prioHi[6] = 1'b1; prioLo[6] = 1'b1;
    pulse("R2 level", 14'h2001, '0);
    expectCall("R2 level", 1'b1, 13);
    chk("R9 level3 set", int'(inService), 8);
    // R6 equal and lower level blocked
    pulse("R6 lower", 14'h0001, '0);
    expectCall("R6 lower", 1'b0, 0);
    pulse("R6 equal", 14'h1000, '0);
    expectCall("R6 equal", 1'b0, 0);
    retire("R9 retire top");
    prioHi = '0; prioLo = '0;

    // R6 nesting and R9 highest-first clear
    prioLo[0] = 1'b1;
    pulse("R6 nest low", 14'h0020, '0);
    expectCall("R6 nest low", 1'b1, 5);
    pulse("R6 nest high", 14'h0002, '0);
    expectCall("R6 nest high", 1'b1, 1);
    chk("R9 two levels", int'(inService), 3);
    retire("R9 clear highest");
    chk("R9 clear highest", int'(inService), 1);
    retire("R9 clear last");
    prioLo = '0;

    // R7 not final cycle, R10 not latched
    flagA = 14'h0008;
    step("R7 capture");
    flagA = '0; lastCycle = 1'b0;
    step("R7 not final");
    expectCall("R7 not final", 1'b0, 0);
    lastCycle = 1'b1;
    step("R10 dropped");
    expectCall("R10 dropped", 1'b0, 0);

    // R8 register write hold-off
    flagA = 14'h0008;
    step("R8 capture");
    flagA = '0; instrIsIrqWrite = 1'b1;
    step("R8 write");
    expectCall("R8 write", 1'b0, 0);
    instrIsIrqWrite = 1'b0;
    // R8 return hold-off, then next instruction vectors
    flagA = 14'h0008;
    step("R8 held capture");
    instrIsReti = 1'b1;
    step("R8 reti");
    expectCall("R8 reti", 1'b0, 0);
    instrIsReti = 1'b0;
    step("R8 next instr");
    expectCall("R8 next instr", 1'b1, 3);
    flagA = '0;
    retire("R9 retire after hold");

    // R4 paired and unpaired second flag
    pulse("R4 paired", '0, 14'h0010);
    expectCall("R4 paired", 1'b1, 4);
    retire("R9 retire pair");
    pulse("R4 unpaired", '0, 14'h0001);
    expectCall("R4 unpaired", 1'b0, 0);
    chk("R4 unpaired inService", int'(inService), 0);

    // R5 enables
    srcEnable[3] = 1'b0;
    pulse("R5 slot disabled", 14'h0008, '0);
    expectCall("R5 slot disabled", 1'b0, 0);
    srcEnable = '1; globalEnable = 1'b0;
    pulse("R5 global off", 14'h0008, '0);
    expectCall("R5 global off", 1'b0, 0);
    globalEnable = 1'b1;

    // mixed random cycles against the model
    for (int k = 0; k < 400; k++) begin
      flagA = N'($urandom() & $urandom());
      flagB = N'($urandom() & $urandom());
      srcEnable = ~N'($urandom() & $urandom() & $urandom());
      globalEnable = ($urandom() % 8) != 0;
      prioLo = G'($urandom());
      prioHi = G'($urandom());
      lastCycle = ($urandom() % 4) != 0;
      instrIsReti = ($urandom() % 5) == 0;
      instrIsIrqWrite = ($urandom() % 8) == 0;
      step("R2 R3 R6 R9 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule